// File: doc/BRIEF.md
# LCD frame timing and mode controller

This block produces the timing skeleton for a multiplexed segment LCD. It is driven by a slow LCD source-clock enable (one-cycle pulses on the system clock). From that tick stream it derives a frame-start strobe, a common-phase strobe with the index of the common line now being driven, and a polarity flag that alternates every frame. The polarity flag lets the pin drivers keep the panel free of DC. How many ticks make up a frame depends on a 2-bit frame-rate code and on the multiplex duty (static, 1/2, 1/3 or 1/4). The 1/3 duty setting uses its own table of lengths.

A small register interface holds the configuration. One register carries the frame-rate code and the duty. A second register carries the display mode: off, normal, all segments forced on, or all segments forced off. The mode is turned into registered qualifiers for the downstream waveform generator. A sleep input forces the display off while it is high. When sleep is released, the mode that was active before sleep comes back.

Top module: `lcd_frame_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x43 (frame code 1, duty 3), the mode register reads 0x00, and drive_en, all_on and all_off are 0.
- R2: Configuration register (address 0): bits 7:6 hold the frame code, bits 2:0 hold the duty, and bits 5:3 always read 0. Mode register (address 1): bits 1:0 hold the mode, and all other bits read 0. rd_data reflects rd_addr one clock later.
- R3: A configuration write whose duty field is 4 to 7 leaves the duty unchanged. The frame code in the same write still takes effect.
- R4: The phase length in source ticks depends on duty (0 static, 1 half, 2 third, 3 quarter) and code c. It is 4(c+1) at duty 0, 2(c+1) at duty 1, c+2 at duty 2 and c+1 at duty 3. This gives frame lengths of 4/8/12/16 ticks, or 6/9/12/15 ticks at 1/3 duty.
- R5: A frame holds N phases, with N = 1, 2, 3, 4 for duty 0..3. com_idx steps from 0 to N-1 on each phase_start and wraps to 0. frame_start always comes together with phase_start and com_idx 0.
- R6: polarity is 0 in the first frame after the display is enabled and inverts at each later frame_start.
- R7: Changes to duty or frame code take effect at the next frame boundary. The current frame completes with the old length.
- R8: Mode encoding is 0 off, 1 normal, 2 all on, 3 all off. In off mode drive_en is 0, no strobes occur, and com_idx and polarity are 0. Mode 1 raises drive_en only. Mode 2 raises drive_en and all_on. Mode 3 raises drive_en and all_off, which tells the waveform stage that the commons are driven statically. The qualifiers follow a mode change one clock later.
- R9: Strobes are one clock wide and appear one clock after the cycle in which tick_en is high. The first tick after the display leaves off mode starts a frame.
- R10: A rising sleep_in forces the mode to 0 (it reads 0). A falling sleep_in restores the mode held before sleep. Mode writes are ignored while sleep_in is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle LCD source-clock enable |
| sleep_in | input | 1 | High while the system sleeps |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 configuration, 1 mode |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address |
| rd_data | output | 8 | Registered read data |
| frame_start | output | 1 | Frame start strobe |
| phase_start | output | 1 | Common phase start strobe |
| com_idx | output | 2 | Index of the active common line |
| polarity | output | 1 | Frame polarity flag |
| drive_en | output | 1 | Display drive enabled |
| all_on | output | 1 | Force all segments on |
| all_off | output | 1 | Force all segments off, static commons |

## Verification
The bench sweeps every duty and code pair. A divider with a wrong entry, in particular reusing the 4/8/12/16 row for 1/3 duty, puts frame_start on the wrong tick. It changes the configuration in the middle of a frame: a design that applies the new length at once ends the running frame early or late. It writes reserved duty values: a design that accepts them stalls the common index or never ends a frame. It also covers sleep entry and exit with mode writes in between: a design that loses the saved mode, or accepts writes while asleep, comes back in the wrong mode.

// File: rtl/lcd_frame_pkg.sv
package lcd_frame_pkg;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned CODE_W  = 2;
  localparam int unsigned DUTY_W  = 3;
  localparam int unsigned COM_W   = 2;
  localparam int unsigned CNT_W   = 5;

  localparam logic [CODE_W-1:0] CODE_RST = 2'd1;
  localparam logic [DUTY_W-1:0] DUTY_RST = 3'd3;
  localparam logic [DUTY_W-1:0] DUTY_MAX = 3'd3;

  localparam logic ADDR_CFG  = 1'b0;
  localparam logic ADDR_MODE = 1'b1;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_NORMAL  = 2'd1,
    MODE_ALL_ON  = 2'd2,
    MODE_ALL_OFF = 2'd3
  } disp_mode_e;

  // ticks per common phase for a given duty and frame code
  function automatic logic [CNT_W-1:0] phase_ticks(input logic [DUTY_W-1:0] duty,
                                                   input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] c1;
    c1 = CNT_W'(code) + CNT_W'(1);
    case (duty)
      3'd0:    phase_ticks = c1 << 2;
      3'd1:    phase_ticks = c1 << 1;
      3'd2:    phase_ticks = CNT_W'(code) + CNT_W'(2);
      default: phase_ticks = c1;
    endcase
  endfunction

  // highest common index used by a duty
  function automatic logic [COM_W-1:0] last_com(input logic [DUTY_W-1:0] duty);
    case (duty)
      3'd0:    last_com = 2'd0;
      3'd1:    last_com = 2'd1;
      3'd2:    last_com = 2'd2;
      default: last_com = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/lcd_frame_regs.sv
module lcd_frame_regs
  import lcd_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_in,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [CODE_W-1:0] cfg_code,
  output logic [DUTY_W-1:0] cfg_duty,
  output disp_mode_e        mode
);

  disp_mode_e saved_mode;
  logic       sleep_q;
  logic       sleep_rise;
  logic       sleep_fall;
  logic       unused_bits;

  assign sleep_rise  = sleep_in & ~sleep_q;
  assign sleep_fall  = ~sleep_in & sleep_q;
  assign unused_bits = ^wr_data[5:3];

  // configuration register
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_code <= CODE_RST;
      cfg_duty <= DUTY_RST;
    end else if (wr_en && wr_addr == ADDR_CFG) begin
      cfg_code <= wr_data[7:6];
      if (wr_data[2:0] <= DUTY_MAX)
        cfg_duty <= wr_data[2:0];
    end
  end

  // mode register with sleep save and restore
  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= MODE_OFF;
      saved_mode <= MODE_OFF;
      sleep_q    <= 1'b0;
    end else begin
      sleep_q <= sleep_in;
      if (sleep_rise) begin
        saved_mode <= mode;
        mode       <= MODE_OFF;
      end else if (sleep_fall) begin
        mode <= saved_mode;
      end else if (!sleep_in && wr_en && wr_addr == ADDR_MODE) begin
        mode <= disp_mode_e'(wr_data[1:0]);
      end
    end
  end

  // registered readback, reserved bits forced to zero
  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_addr == ADDR_MODE)
      rd_data <= {{(REG_W-2){1'b0}}, mode};
    else
      rd_data <= {cfg_code, 3'b000, cfg_duty};
  end

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
  import lcd_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              active,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic [DUTY_W-1:0] cfg_duty,
  output logic              frame_start,
  output logic              phase_start,
  output logic [COM_W-1:0]  com_idx,
  output logic              polarity
);

  logic              started;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] act_code;
  logic [DUTY_W-1:0] act_duty;
  logic [CNT_W-1:0]  cnt_last;
  logic              phase_end;
  logic              frame_end;

  assign cnt_last  = phase_ticks(act_duty, act_code) - CNT_W'(1);
  assign phase_end = (cnt == cnt_last);
  assign frame_end = phase_end && (com_idx == last_com(act_duty));

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      started     <= 1'b0;
      cnt         <= '0;
      com_idx     <= '0;
      polarity    <= 1'b0;
      frame_start <= 1'b0;
      phase_start <= 1'b0;
      act_code    <= CODE_RST;
      act_duty    <= DUTY_RST;
    end else begin
      frame_start <= 1'b0;
      phase_start <= 1'b0;
      if (tick_en) begin
        if (!started) begin
          started     <= 1'b1;
          frame_start <= 1'b1;
          phase_start <= 1'b1;
          com_idx     <= '0;
          polarity    <= 1'b0;
          cnt         <= '0;
          act_code    <= cfg_code;
          act_duty    <= cfg_duty;
        end else if (frame_end) begin
          frame_start <= 1'b1;
          phase_start <= 1'b1;
          com_idx     <= '0;
          polarity    <= ~polarity;
          cnt         <= '0;
          act_code    <= cfg_code;
          act_duty    <= cfg_duty;
        end else if (phase_end) begin
          phase_start <= 1'b1;
          com_idx     <= com_idx + COM_W'(1);
          cnt         <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/lcd_frame_qual.sv
module lcd_frame_qual
  import lcd_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  disp_mode_e mode,
  output logic       drive_en,
  output logic       all_on,
  output logic       all_off
);

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_en <= 1'b0;
      all_on   <= 1'b0;
      all_off  <= 1'b0;
    end else begin
      drive_en <= (mode != MODE_OFF);
      all_on   <= (mode == MODE_ALL_ON);
      all_off  <= (mode == MODE_ALL_OFF);
    end
  end

endmodule

// File: rtl/lcd_frame_ctrl.sv
module lcd_frame_ctrl
  import lcd_frame_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             sleep_in,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [REG_W-1:0] rd_data,
  output logic             frame_start,
  output logic             phase_start,
  output logic [COM_W-1:0] com_idx,
  output logic             polarity,
  output logic             drive_en,
  output logic             all_on,
  output logic             all_off
);

  logic [CODE_W-1:0] cfg_code;
  logic [DUTY_W-1:0] cfg_duty;
  disp_mode_e        mode;

  lcd_frame_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .sleep_in (sleep_in),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .cfg_code (cfg_code),
    .cfg_duty (cfg_duty),
    .mode     (mode)
  );

  lcd_frame_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .tick_en     (tick_en),
    .active      (mode != MODE_OFF),
    .cfg_code    (cfg_code),
    .cfg_duty    (cfg_duty),
    .frame_start (frame_start),
    .phase_start (phase_start),
    .com_idx     (com_idx),
    .polarity    (polarity)
  );

  lcd_frame_qual u_qual (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .drive_en (drive_en),
    .all_on   (all_on),
    .all_off  (all_off)
  );

endmodule

// File: rtl/lcd_frame_ctrl_chk.sv
module lcd_frame_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       sleep_in,
  input logic       rd_addr,
  input logic [7:0] rd_data,
  input logic       frame_start,
  input logic       phase_start,
  input logic [1:0] com_idx,
  input logic       polarity,
  input logic       drive_en,
  input logic       all_on,
  input logic       all_off
);

  p_off_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !drive_en |-> (!phase_start && !frame_start));

  p_mode_excl_r8: assert property (@(posedge clk) disable iff (rst)
    (all_on || all_off) |-> drive_en);

  p_frame_head_r5: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (phase_start && com_idx == 2'd0));

  p_com_step_r5: assert property (@(posedge clk) disable iff (rst)
    (phase_start && !frame_start) |-> (com_idx == $past(com_idx) + 2'd1));

  p_pol_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (drive_en && $past(drive_en) && !frame_start) |-> $stable(polarity));

  p_sleep_off_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(sleep_in) && $past(sleep_in, 2)) |-> !drive_en);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == 1'b0) |-> (rd_data[5:3] == 3'b000));

endmodule

bind lcd_frame_ctrl lcd_frame_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .sleep_in    (sleep_in),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .frame_start (frame_start),
  .phase_start (phase_start),
  .com_idx     (com_idx),
  .polarity    (polarity),
  .drive_en    (drive_en),
  .all_on      (all_on),
  .all_off     (all_off)
);

// File: tb/lcd_frame_ctrl_bench.sv
module lcd_frame_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       sleep_in = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       frame_start, phase_start, polarity, drive_en, all_on, all_off;
  logic [1:0] com_idx;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  logic [1:0] m_code = 2'd1, m_acode = 2'd1;
  logic [2:0] m_duty = 3'd3, m_aduty = 3'd3;
  logic [1:0] m_mode = 2'd0, m_saved = 2'd0;
  logic       m_started = 1'b0, m_pol = 1'b0;
  logic [1:0] m_com = 2'd0;
  int         m_cnt = 0;

  always #4 clk = ~clk;

  lcd_frame_ctrl u_lcd_frame_ctrl (
    .clk(clk), .rst(rst), .tick_en(tick_en), .sleep_in(sleep_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .frame_start(frame_start), .phase_start(phase_start),
    .com_idx(com_idx), .polarity(polarity), .drive_en(drive_en),
    .all_on(all_on), .all_off(all_off)
  );

  function automatic int exp_phase(input logic [2:0] d, input logic [1:0] c);
    case (d)
      3'd0:    return 4 * (int'(c) + 1);
      3'd1:    return 2 * (int'(c) + 1);
      3'd2:    return int'(c) + 2;
      default: return int'(c) + 1;
    endcase
  endfunction

  function automatic logic [1:0] exp_last(input logic [2:0] d);
    return (d > 3'd3) ? 2'd3 : d[1:0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(output logic fs);
    logic efs, eps;
    @(negedge clk) tick_en = 1'b1;
    @(negedge clk) tick_en = 1'b0;
    efs = 1'b0; eps = 1'b0;
    if (m_mode != 2'd0) begin
      if (!m_started) begin
        m_started = 1'b1; efs = 1'b1; eps = 1'b1; m_com = 2'd0; m_pol = 1'b0;
        m_cnt = 0; m_aduty = m_duty; m_acode = m_code;
      end else if (m_cnt == exp_phase(m_aduty, m_acode) - 1) begin
        m_cnt = 0; eps = 1'b1;
        if (m_com == exp_last(m_aduty)) begin
          m_com = 2'd0; efs = 1'b1; m_pol = ~m_pol; m_aduty = m_duty; m_acode = m_code;
        end else m_com = m_com + 2'd1;
      end else m_cnt++;
    end
    check("R4 frame_start", int'(frame_start), int'(efs));
    check("R5 phase_start", int'(phase_start), int'(eps));
    check("R5 com_idx", int'(com_idx), int'(m_com));
    check("R6 polarity", int'(polarity), int'(m_pol));
    fs = frame_start;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check("R9 strobe idle", int'(frame_start | phase_start), 0);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
    if (a == 1'b0) begin
      m_code = d[7:6];
      if (d[2:0] <= 3'd3) m_duty = d[2:0];
    end else if (!sleep_in) begin
      m_mode = d[1:0];
      if (m_mode == 2'd0) begin m_started = 1'b0; m_com = 2'd0; m_pol = 1'b0; end
    end
    @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk) rd_addr = a;
    @(negedge clk) v = rd_data;
  endtask

  task automatic set_sleep(input logic v);
    @(negedge clk) sleep_in = v;
    if (v) begin
      m_saved = m_mode; m_mode = 2'd0; m_started = 1'b0; m_com = 2'd0; m_pol = 1'b0;
    end else m_mode = m_saved;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_qual(input string req);
    check({req, " drive_en"}, int'(drive_en), int'(m_mode != 2'd0));
    check({req, " all_on"},   int'(all_on),   int'(m_mode == 2'd2));
    check({req, " all_off"},  int'(all_off),  int'(m_mode == 2'd3));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic fs;
    int cnt;
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); check("R1 cfg reset", int'(v), 8'h43);
    rd(1'b1, v); check("R1 mode reset", int'(v), 8'h00);
    check_qual("R1");
    // R8 ticks while off do nothing
    for (int i = 0; i < 5; i++) tick(fs);

    // R2 layout, reserved bits read zero
    wr(1'b0, 8'hBA);
    rd(1'b0, v); check("R2 cfg readback", int'(v), 8'h82);
    wr(1'b1, 8'hFD);
    rd(1'b1, v); check("R2 mode readback", int'(v), 8'h01);
    // R3 reserved duty ignored, code still taken
    wr(1'b0, 8'h47);
    rd(1'b0, v); check("R3 reserved duty", int'(v), 8'h42);
    wr(1'b0, 8'h03);

    // R8 qualifier decode for each mode
    for (int md = 0; md < 4; md++) begin
      wr(1'b1, 8'(md));
      check_qual("R8");
    end

    // R4/R5 sweep every duty and code, two frames each
    for (int d = 0; d < 4; d++) begin
      for (int c = 0; c < 4; c++) begin
        wr(1'b1, 8'h00);
        wr(1'b0, {2'(c), 3'b000, 3'(d)});
        wr(1'b1, 8'h01);
        tick(fs);
        check("R9 first tick starts frame", int'(fs), 1);
        cnt = 0;
        do begin tick(fs); cnt++; end while (!fs && cnt < 40);
        check("R4 frame length", cnt, exp_phase(3'(d), 2'(c)) * (d + 1));
        for (int k = 0; k < 20; k++) tick(fs);
      end
    end

    // R7 mid-frame change applies at next boundary
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h03);
    wr(1'b1, 8'h01);
    tick(fs);
    tick(fs);
    wr(1'b0, 8'hC3);
    tick(fs); check("R7 old length kept", int'(fs), 0);
    tick(fs); check("R7 old length kept", int'(fs), 0);
    tick(fs); check("R7 boundary", int'(fs), 1);
    cnt = 0;
    do begin tick(fs); cnt++; end while (!fs && cnt < 40);
    check("R7 new length", cnt, 16);

    // R10 sleep save and restore, writes ignored while asleep
    wr(1'b1, 8'h02);
    set_sleep(1'b1);
    rd(1'b1, v); check("R10 mode in sleep", int'(v), 0);
    check_qual("R10 asleep");
    wr(1'b1, 8'h03);
    rd(1'b1, v); check("R10 write ignored", int'(v), 0);
    tick(fs); check("R10 no frame asleep", int'(fs), 0);
    set_sleep(1'b0);
    rd(1'b1, v); check("R10 restored", int'(v), 2);
    check_qual("R10 awake");
    tick(fs); check("R10 restart frame", int'(fs), 1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) wr(1'b0, 8'($urandom));
      else if (r == 1) wr(1'b1, 8'(($urandom % 8 == 0) ? 0 : 1 + $urandom % 3));
      else if (r == 2) begin set_sleep(1'b1); set_sleep(1'b0); end
      else begin
        tick(fs);
        idle(int'($urandom % 3));
      end
      if (r <= 2) check_qual("R8 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule